// File: doc/BRIEF.md
# Expansion Bus Interface Register Block

This block holds the small set of registers that an expansion-bus interface chip exposes to its local processor. It answers two address windows. In the direct window sit a 32-bit control word and the write side of a 32-bit board identification word. In the slot window, at the very top of the local processor's own slot, sit an interrupt status byte, an interrupt mask byte and the read side of the identification word, laid out one byte per longword.

Requests arrive on a single-cycle synchronous bus with byte, word and longword sizes. Each request gets exactly one response on the next cycle, carrying read data or a bus error. An interrupt source input is sampled into the status bit. The interrupt output is raised when the sampled status and the mask bit are both set.

Top module: `ebus_regs`

## Requirements
- R1: After reset the control word, identification word, status bit and mask bit are all zero, irq_o is low and rsp_valid_o is low.
- R2: In the direct window (win_i=0), offsets 0 to 3 hold the control word, readable and writable by byte, word or longword. The order is big-endian: offset 0 is bits 31:24. Bit 28 (ignore slot-number LSB), bit 27 (store-forward enable) and bit 26 (read-modify collision flag) are kept like the other bits, and all 32 bits read back as written.
- R3: Direct-window offsets 4 to 7 write the identification word big-endian (bit 31 valid, bits 30:16 maker code, bits 15:0 board code). A read of any of these offsets returns a bus error.
- R4: A direct-window access whose address bits 15:0 exceed 7 returns a bus error and changes no register. Address bits above 15 are ignored in that window.
- R5: A slot-window access (win_i=1) whose address bits 23:0 are below 0xFFFFE8 returns a bus error. Otherwise the byte is chosen by address bits 4:0.
- R6: Slot-window reads: byte 0x08 returns the status bit in bit 7, and byte 0x0C returns the mask bit in bit 7. Bytes 0x10, 0x14, 0x18 and 0x1C return identification bits 31:24, 23:16, 15:8 and 7:0 in that order. Every other byte from 0x09 to 0x1F reads as zero.
- R7: Slot-window writes: byte 0x0C stores data bit 7 as the mask bit, and its other bits read back as zero. Bytes 0x0D to 0x0F accept writes without error and ignore them. Any other slot-window write returns a bus error and changes nothing.
- R8: A longword access (size_i=2) with address bits 1:0 not zero, a word access (size_i=1) with address bit 0 set, or size_i=3 returns a bus error and changes no register. A transfer with any erroring byte gives a single bus error for the whole transfer.
- R9: rsp_valid_o is high for one cycle, the cycle after each request, and only then. Read data is right-justified: for a longword, the lowest address is in bits 31:24; for a word, in bits 15:8; for a byte, in bits 7:0 (size_i 0 is byte). A write response or an error response carries zero data.
- R10: The status bit copies irq_src_i one cycle late, and irq_o is high exactly when the status and mask bits are both set. A status read in the same cycle that irq_src_i changes returns the value from before the change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request valid for one cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| win_i | input | 1 | 0 = direct window, 1 = slot window |
| size_i | input | 2 | 0 byte, 1 word, 2 longword, 3 illegal |
| addr_i | input | 24 | Byte address |
| wdata_i | input | 32 | Right-justified write data |
| irq_src_i | input | 1 | Interrupt source level |
| rsp_valid_o | output | 1 | Response strobe, one cycle after request |
| berr_o | output | 1 | Bus error for the answered request |
| rdata_o | output | 32 | Right-justified read data |
| irq_o | output | 1 | Interrupt request out |

## Verification
The status sampler runs every cycle, so a change on the interrupt source can land in the same cycle as a bus access to the status byte or the mask byte. The bench raises irq_src_i on the same edge as a status read and expects the old value in the response, then the new value on the next read. It also writes the mask at the moment the source falls, and it judges irq_o one cycle after each such coincidence.

// File: rtl/ebus_pkg.sv
package ebus_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2,
    SZ_BAD  = 2'd3
  } xfer_size_e;

  // Byte enables and data are indexed by register bit position
  typedef struct packed {
    logic [3:0]  ctrl_be;
    logic [31:0] ctrl_d;
    logic [3:0]  id_be;
    logic [31:0] id_d;
    logic        mask_we;
    logic        mask_d;
  } wr_req_t;

  function automatic logic [2:0] size_bytes(input logic [1:0] s);
    case (s)
      SZ_BYTE: return 3'd1;
      SZ_WORD: return 3'd2;
      SZ_LONG: return 3'd4;
      default: return 3'd0;
    endcase
  endfunction

  // Byte j of a big-endian word (j=0 is most significant)
  function automatic logic [7:0] be_byte(input logic [31:0] r, input logic [1:0] j);
    return r[8*(3-int'(j)) +: 8];
  endfunction

endpackage

// File: rtl/ebus_lane_decode.sv
module ebus_lane_decode
  import ebus_pkg::*;
(
  input  logic        slot_i,
  input  logic [4:0]  off_i,
  input  logic [31:0] ctrl_i,
  input  logic [31:0] id_i,
  input  logic        stat_i,
  input  logic        mask_i,
  output logic [7:0]  rd_byte_o,
  output logic        rd_err_o,
  output logic        wr_err_o,
  output logic        wr_ctrl_o,
  output logic        wr_id_o,
  output logic        wr_mask_o
);

  always_comb begin
    rd_byte_o = '0;
    rd_err_o  = 1'b0;
    wr_err_o  = 1'b0;
    wr_ctrl_o = 1'b0;
    wr_id_o   = 1'b0;
    wr_mask_o = 1'b0;
    if (!slot_i) begin
      // range beyond offset 7 is rejected at the top
      if (!off_i[2]) begin
        rd_byte_o = be_byte(ctrl_i, off_i[1:0]);
        wr_ctrl_o = 1'b1;
      end else begin
        rd_err_o = 1'b1;
        wr_id_o  = 1'b1;
      end
    end else begin
      case (off_i[4:2])
        3'd0, 3'd1: begin
          rd_err_o = 1'b1;
          wr_err_o = 1'b1;
        end
        3'd2: begin
          wr_err_o = 1'b1;
          if (off_i[1:0] == 2'd0) rd_byte_o = {stat_i, 7'b0};
        end
        3'd3: begin
          if (off_i[1:0] == 2'd0) begin
            rd_byte_o = {mask_i, 7'b0};
            wr_mask_o = 1'b1;
          end
        end
        default: begin
          wr_err_o = 1'b1;
          if (off_i[1:0] == 2'd0) rd_byte_o = be_byte(id_i, off_i[3:2]);
        end
      endcase
    end
  end

endmodule

// File: rtl/ebus_regfile.sv
module ebus_regfile
  import ebus_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          commit_i,
  input  wr_req_t       wr_i,
  input  logic          irq_src_i,
  output logic [DW-1:0] ctrl_o,
  output logic [DW-1:0] id_o,
  output logic          stat_o,
  output logic          mask_o,
  output logic          irq_o
);

  localparam int NB = DW / 8;

  logic [DW-1:0] ctrl_q, id_q;
  logic          stat_q, mask_q;

  for (genvar b = 0; b < NB; b++) begin : g_byte
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ctrl_q[8*b +: 8] <= '0;
        id_q[8*b +: 8]   <= '0;
      end else if (commit_i) begin
        if (wr_i.ctrl_be[b]) ctrl_q[8*b +: 8] <= wr_i.ctrl_d[8*b +: 8];
        if (wr_i.id_be[b])   id_q[8*b +: 8]   <= wr_i.id_d[8*b +: 8];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= 1'b0;
      mask_q <= 1'b0;
    end else begin
      stat_q <= irq_src_i;
      if (commit_i && wr_i.mask_we) mask_q <= wr_i.mask_d;
    end
  end

  assign ctrl_o = ctrl_q;
  assign id_o   = id_q;
  assign stat_o = stat_q;
  assign mask_o = mask_q;
  assign irq_o  = stat_q & mask_q;

endmodule

// File: rtl/ebus_regs.sv
module ebus_regs
  import ebus_pkg::*;
#(
  parameter int          AW          = 24,
  parameter int          DW          = 32,
  parameter logic [23:0] SLOT_BASE   = 24'hFFFFE8,
  parameter int          DIRECT_LAST = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic          win_i,
  input  logic [1:0]    size_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          irq_src_i,
  output logic          rsp_valid_o,
  output logic          berr_o,
  output logic [DW-1:0] rdata_o,
  output logic          irq_o
);

  localparam int NL = DW / 8;

  logic [DW-1:0] ctrl, id;
  logic          stat, mask;
  logic [2:0]    nbytes;
  logic          misalign, range_err, lane_err, any_err, commit;
  logic [NL-1:0] lane_act, lane_rerr, lane_werr, lane_wc, lane_wi, lane_wm;
  logic [7:0]    lane_rd  [NL];
  logic [4:0]    lane_off [NL];
  logic [DW-1:0] rd_c;
  wr_req_t       wr;

  assign nbytes = size_bytes(size_i);

  assign misalign = (size_i == SZ_BAD) ||
                    (size_i == SZ_LONG && addr_i[1:0] != 2'd0) ||
                    (size_i == SZ_WORD && addr_i[0]);

  assign range_err = win_i ? (addr_i[23:0] < SLOT_BASE)
                           : (addr_i[15:0] > 16'(DIRECT_LAST));

  for (genvar k = 0; k < NL; k++) begin : g_lane
    assign lane_off[k] = addr_i[4:0] + 5'(k);
    assign lane_act[k] = 3'(k) < nbytes;
    ebus_lane_decode u_dec (
      .slot_i    (win_i),
      .off_i     (lane_off[k]),
      .ctrl_i    (ctrl),
      .id_i      (id),
      .stat_i    (stat),
      .mask_i    (mask),
      .rd_byte_o (lane_rd[k]),
      .rd_err_o  (lane_rerr[k]),
      .wr_err_o  (lane_werr[k]),
      .wr_ctrl_o (lane_wc[k]),
      .wr_id_o   (lane_wi[k]),
      .wr_mask_o (lane_wm[k])
    );
  end

  assign lane_err = |(lane_act & (we_i ? lane_werr : lane_rerr));
  assign any_err  = misalign | range_err | lane_err;
  assign commit   = req_i & we_i & ~any_err;

  // Gather read bytes and scatter write bytes, big-endian, right-justified
  always_comb begin
    int sh;
    int j;
    logic [7:0] wb;
    rd_c = '0;
    wr   = '0;
    sh   = 0;
    j    = 0;
    wb   = '0;
    for (int k = 0; k < NL; k++) begin
      if (lane_act[k]) begin
        sh = 8 * (int'(nbytes) - 1 - k);
        rd_c = rd_c | (DW'(lane_rd[k]) << sh);
        wb = 8'(wdata_i >> sh);
        j  = 3 - int'(lane_off[k][1:0]);
        if (lane_wc[k]) begin
          wr.ctrl_be[j]        = 1'b1;
          wr.ctrl_d[8*j +: 8]  = wb;
        end
        if (lane_wi[k]) begin
          wr.id_be[j]          = 1'b1;
          wr.id_d[8*j +: 8]    = wb;
        end
        if (lane_wm[k]) begin
          wr.mask_we = 1'b1;
          wr.mask_d  = wb[7];
        end
      end
    end
  end

  ebus_regfile #(.DW(DW)) u_rf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .commit_i  (commit),
    .wr_i      (wr),
    .irq_src_i (irq_src_i),
    .ctrl_o    (ctrl),
    .id_o      (id),
    .stat_o    (stat),
    .mask_o    (mask),
    .irq_o     (irq_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      berr_o      <= 1'b0;
      rdata_o     <= '0;
    end else begin
      rsp_valid_o <= req_i;
      berr_o      <= req_i & any_err;
      rdata_o     <= (req_i && !we_i && !any_err) ? rd_c : '0;
    end
  end

endmodule

// File: rtl/ebus_regs_chk.sv
module ebus_regs_chk #(
  parameter int          AW        = 24,
  parameter int          DW        = 32,
  parameter logic [23:0] SLOT_BASE = 24'hFFFFE8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_i,
  input logic          we_i,
  input logic          win_i,
  input logic [1:0]    size_i,
  input logic [AW-1:0] addr_i,
  input logic [DW-1:0] wdata_i,
  input logic          irq_src_i,
  input logic          rsp_valid_o,
  input logic          berr_o,
  input logic [DW-1:0] rdata_o,
  input logic          irq_o
);

  p_rsp_follows_req_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> rsp_valid_o);

  p_idle_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !rsp_valid_o);

  p_err_zero_data_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && berr_o) |-> (rdata_o == '0));

  p_write_zero_data_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i) |=> (rdata_o == '0));

  p_misalign_err_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && (size_i == 2'd3 || (size_i == 2'd2 && addr_i[1:0] != 2'd0) ||
               (size_i == 2'd1 && addr_i[0]))) |=> berr_o);

  p_direct_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !win_i && addr_i[15:0] > 16'd7) |=> berr_o);

  p_slot_range_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && win_i && addr_i[23:0] < SLOT_BASE) |=> berr_o);

  p_direct_id_read_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && !win_i && addr_i[15:0] >= 16'd4 && addr_i[15:0] <= 16'd7) |=> berr_o);

  p_src_low_irq_low_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_src_i |=> !irq_o);

endmodule

bind ebus_regs ebus_regs_chk #(.AW(AW), .DW(DW), .SLOT_BASE(SLOT_BASE)) u_chk (.*);

// File: tb/ebus_regs_bench.sv
`timescale 1ns/1ps
module ebus_regs_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0, win = 1'b0, irq_src = 1'b0;
  logic [1:0]  size = 2'd0;
  logic [23:0] addr = '0;
  logic [31:0] wdata = '0;
  logic        rsp_valid_o, berr_o, irq_o;
  logic [31:0] rdata_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [32:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  ebus_regs u_ebus_regs (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .req_i       (req),
    .we_i        (we),
    .win_i       (win),
    .size_i      (size),
    .addr_i      (addr),
    .wdata_i     (wdata),
    .irq_src_i   (irq_src),
    .rsp_valid_o (rsp_valid_o),
    .berr_o      (berr_o),
    .rdata_o     (rdata_o),
    .irq_o       (irq_o)
  );

  task automatic check(input string t, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", t, act, exp);
    end
  endtask

  // Driver: one request, called at a negative edge, returns at the next one
  task automatic acc(input logic w, input logic s, input logic [1:0] sz,
                     input logic [23:0] a, input logic [31:0] d,
                     input logic eb, input logic [31:0] ed, input string t);
    req = 1'b1; we = w; win = s; size = sz; addr = a; wdata = d;
    exp_q.push_back({eb, ed});
    tag_q.push_back(t);
    @(negedge clk);
    req = 1'b0;
  endtask

  // Monitor: scoreboard comparison of each response
  always @(negedge clk) begin
    if (rst_n && rsp_valid_o) begin
      if (exp_q.size() == 0) begin
        n_chk++;
        n_fail++;
        $display("FAIL R9 unexpected response actual=%h expected=none", rdata_o);
      end else begin
        logic [32:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        n_chk++;
        if ({berr_o, rdata_o} !== e)  begin
          n_fail++;
          $display("FAIL %s actual=berr %b data %h expected=berr %b data %h",
                   t, berr_o, rdata_o, e[32], e[31:0]);
        end
      end
    end
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 rsp_valid in reset", {31'b0, rsp_valid_o}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 irq after reset", {31'b0, irq_o}, 32'd0);
    check("R1 rsp_valid after reset", {31'b0, rsp_valid_o}, 32'd0);
    acc(0, 0, 2, 24'h000000, 0, 0, 32'h0, "R1 control zero");
    acc(0, 1, 0, 24'hFFFFEC, 0, 0, 32'h0, "R1 mask zero");
    acc(0, 1, 2, 24'hFFFFF0, 0, 0, 32'h0, "R1 id zero");

    // R2 control word
    acc(1, 0, 2, 24'h000000, 32'h1C00A55A, 0, 0, "R2 long write");
    acc(0, 0, 2, 24'h000000, 0, 0, 32'h1C00A55A, "R2 long read");
    acc(1, 0, 0, 24'h000001, 32'h77, 0, 0, "R2 byte write off1");
    acc(0, 0, 1, 24'h000002, 0, 0, 32'h0000A55A, "R2 word read off2");
    acc(0, 0, 0, 24'h000000, 0, 0, 32'h1C, "R2 byte read off0");
    acc(0, 0, 0, 24'h000001, 0, 0, 32'h77, "R2 byte read off1");
    acc(1, 0, 1, 24'h000000, 32'h0812, 0, 0, "R2 word write off0");
    acc(0, 0, 2, 24'h000000, 0, 0, 32'h0812A55A, "R2 long readback");

    // R3 identification word
    acc(1, 0, 2, 24'h000004, 32'h8123BEEF, 0, 0, "R3 id long write");
    acc(0, 0, 2, 24'h000004, 0, 1, 0, "R3 direct id long read");
    acc(0, 0, 0, 24'h000006, 0, 1, 0, "R3 direct id byte read");
    acc(0, 1, 2, 24'hFFFFF0, 0, 0, 32'h81000000, "R6 id byte 3");
    acc(0, 1, 2, 24'hFFFFF4, 0, 0, 32'h23000000, "R6 id byte 2");
    acc(0, 1, 0, 24'hFFFFF8, 0, 0, 32'hBE, "R6 id byte 1");
    acc(0, 1, 2, 24'hFFFFFC, 0, 0, 32'hEF000000, "R6 id byte 0");
    acc(1, 0, 1, 24'h000006, 32'h1234, 0, 0, "R3 id word write");
    acc(0, 1, 0, 24'hFFFFFC, 0, 0, 32'h34, "R3 id low byte");
    acc(0, 1, 0, 24'hFFFFFD, 0, 0, 32'h0, "R6 pad byte");
    acc(0, 1, 0, 24'hFFFFF8, 0, 0, 32'h12, "R3 id byte 1 after word");

    // R4 direct range
    acc(0, 0, 0, 24'h000008, 0, 1, 0, "R4 byte read off8");
    acc(1, 0, 2, 24'h000010, 32'hFFFFFFFF, 1, 0, "R4 far write");
    acc(0, 0, 2, 24'h120000, 0, 0, 32'h0812A55A, "R4 upper bits ignored");

    // R5 slot range
    acc(0, 1, 0, 24'hFFFFE7, 0, 1, 0, "R5 below window");
    acc(0, 1, 0, 24'h00FFE8, 0, 1, 0, "R5 low address");
    acc(0, 1, 2, 24'hFFFFE8, 0, 0, 32'h0, "R5 window start");

    // R7 slot writes
    acc(1, 1, 0, 24'hFFFFEC, 32'hFF, 0, 0, "R7 mask write");
    acc(0, 1, 0, 24'hFFFFEC, 0, 0, 32'h80, "R7 mask read");
    acc(1, 1, 0, 24'hFFFFED, 32'h55, 0, 0, "R7 pad write ignored");
    acc(0, 1, 2, 24'hFFFFEC, 0, 0, 32'h80000000, "R7 mask word after pad");
    acc(1, 1, 0, 24'hFFFFE8, 32'h00, 1, 0, "R7 status write");
    acc(1, 1, 2, 24'hFFFFF0, 32'h0, 1, 0, "R7 id slot write");
    acc(0, 1, 2, 24'hFFFFF0, 0, 0, 32'h81000000, "R7 id unchanged");

    // R8 misalignment
    acc(0, 0, 2, 24'h000002, 0, 1, 0, "R8 long misaligned");
    acc(1, 0, 1, 24'h000001, 32'hDEAD, 1, 0, "R8 word odd write");
    acc(0, 0, 3, 24'h000000, 0, 1, 0, "R8 illegal size");
    acc(0, 1, 1, 24'hFFFFED, 0, 1, 0, "R8 slot word odd");
    acc(0, 0, 2, 24'h000000, 0, 0, 32'h0812A55A, "R8 control unchanged");

    // R9 formatting
    acc(0, 1, 1, 24'hFFFFEC, 0, 0, 32'h00008000, "R9 word justify");
    acc(0, 0, 1, 24'h000000, 0, 0, 32'h00000812, "R9 word high half");

    // R10 interrupt path, mask is set
    check("R10 irq with source low", {31'b0, irq_o}, 32'd0);
    irq_src = 1'b1;
    acc(0, 1, 0, 24'hFFFFE8, 0, 0, 32'h0, "R10 status read on source edge");
    check("R10 irq after source rise", {31'b0, irq_o}, 32'd1);
    acc(0, 1, 0, 24'hFFFFE8, 0, 0, 32'h80, "R10 status read later");
    acc(1, 1, 0, 24'hFFFFEC, 32'h00, 0, 0, "R10 mask clear");
    check("R10 irq masked", {31'b0, irq_o}, 32'd0);
    irq_src = 1'b0;
    acc(1, 1, 0, 24'hFFFFEC, 32'h80, 0, 0, "R10 mask set as source falls");
    check("R10 irq source low mask set", {31'b0, irq_o}, 32'd0);
    irq_src = 1'b1;
    @(negedge clk);
    check("R10 irq source rise mask set", {31'b0, irq_o}, 32'd1);

    repeat (3) @(negedge clk);
    check("R9 all responses seen", exp_q.size(), 32'd0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule